// File: doc/BRIEF.md
# Multichannel Frame Alignment FIFO

This block receives up to four byte-wide receive lanes. Each lane runs on its own recovered clock and carries a frame-start marker with each byte. The block delivers the lanes on one common read clock. Each lane feeds a small dual-clock FIFO whose write and read pointers cross between clock domains in Gray code. All lanes run at exactly the same byte rate, so the block does no rate adaptation and never inserts or deletes filler bytes.

In grouped mode the lanes form one wide stream. The controller hunts for the frame start on every lane: it discards the bytes ahead of each lane's frame start and holds a lane once its frame-start byte reaches the head of its FIFO. When every lane holds a frame start, it releases all lanes together and reads them in lockstep from then on. A lane that lags the earliest lane by more than 18 bytes raises an alignment error, and so does a read word that carries a frame start on some lanes but not on the others. After either error the controller drops the affected bytes and re-arms on the next frame. A write into a full lane FIFO is dropped, and in grouped mode it also counts as an alignment error.

In independent mode each lane is simply moved into the read clock domain and emitted as soon as it is visible. The mode input is quasi-static and is changed only while reset is held.

Top module: `lane_deskew_fifo`

## Requirements
- R1: In independent mode every lane emits each byte it was given, in order, including the bytes before its first frame start. The frame-start flag stays attached to its byte, and `aligned` and `align_err` stay low.
- R2: In grouped mode the bytes ahead of each lane's frame start are discarded. The first word emitted after reset, and the first word emitted after any alignment error, is a frame-start word.
- R3: In grouped mode `rd_valid` is either all ones or all zeros in every cycle.
- R4: In grouped mode, with lane skews of up to 18 bytes, each emitted word carries the same stream position on every lane. A frame start is flagged on all lanes in the same cycle.
- R5: Once grouped lanes are locked, no byte is dropped or repeated: consecutive emitted words hold consecutive stream positions.
- R6: `aligned` rises in the cycle in which the first all-lane frame-start word is emitted. It stays high while the lock holds.
- R7: If one lane holds its frame start for more than 18 read cycles while another lane has not yet reached its own, `align_err` pulses for one cycle and no word is emitted in that cycle. With a constant skew of 24 bytes the group never locks, no data is emitted, and `aligned` stays low.
- R8: If, while locked, a read word carries a frame start on some lanes but not all, that word is dropped, `align_err` pulses, and `aligned` falls in the same cycle. The group then relocks on the next frame start that all lanes share.
- R9: While reset is asserted, `rd_valid`, `aligned` and `align_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset, synchronized into every clock domain |
| wr_clk | input | LANES | Recovered write clock of each lane |
| wr_valid | input | LANES | Byte present on the lane in this write cycle |
| wr_data | input | LANES*DW | Lane bytes, lane n in bits n*DW and up |
| wr_sof | input | LANES | Frame-start marker for the lane byte |
| rd_clk | input | 1 | Common output clock |
| group_mode | input | 1 | 1: lanes aligned as one group; 0: independent domain transfer |
| rd_valid | output | LANES | Output byte valid per lane |
| rd_data | output | LANES*DW | Output bytes, same lane packing as the input |
| rd_sof | output | LANES | Frame-start marker of each output byte |
| aligned | output | 1 | Group locked with frame starts coincident |
| align_err | output | 1 | One-cycle pulse on a skew violation, split frame start or overflow |

## Verification
The bound checker watches every read cycle for the following: grouped valids that are not all-or-nothing, grouped frame-start flags that differ between lanes, a pop from an empty lane FIFO, a hunt counter beyond its limit, and an error pulse that coincides with emitted data or a raised `aligned`. It also checks that `aligned` rises only together with a full frame-start word and that the status outputs stay low in independent mode. Other properties need whole streams and can only be shown by the bench's scenarios. These are: that the emitted bytes on different lanes are really the same stream position, that nothing is lost or repeated, that bytes ahead of a frame start are discarded, that a skew of 17 bytes is absorbed while 24 never locks, and that the group relocks after an injected false frame start.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  typedef enum logic {
    GRP_HUNT = 1'b0,
    GRP_LOCK = 1'b1
  } grp_state_e;

  // A lane has waited too long for its partners once the wait passes the limit.
  function automatic logic skew_over(input int waited, input int limit);
    return waited > limit;
  endfunction

  // Width of a counter able to hold limit+1.
  function automatic int wait_width(input int limit);
    return $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/lane_deskew_sync.sv
module lane_deskew_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lane_deskew_lane_fifo.sv
module lane_deskew_lane_fifo #(
  parameter int DW          = 8,
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sof,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic          rd_empty,
  output logic [DW-1:0] rd_head,
  output logic          rd_head_sof,
  output logic          rd_ovf_evt
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW:0]   store [DEPTH];
  logic [PW-1:0] wbin, wbin_nx, wgray, rgray_w;
  logic [PW-1:0] rbin, rbin_nx, rgray, wgray_r;
  logic          wr_full, push, take;
  logic          ovf_tgl, ovf_s, ovf_d;

  // write side
  lane_deskew_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w)
  );

  assign wr_full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign push    = wr_valid & ~wr_full;
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      ovf_tgl <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= to_gray(wbin_nx);
      end
      if (wr_valid && wr_full) ovf_tgl <= ~ovf_tgl;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (push) store[wbin[AW-1:0]] <= {wr_sof, wr_data};
  end

  // read side
  lane_deskew_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r)
  );

  assign rd_empty = (rgray == wgray_r);
  assign take     = rd_pop & ~rd_empty;
  assign rbin_nx  = rbin + PW'(1);
  assign {rd_head_sof, rd_head} = store[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (take) begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end
  end

  // overflow event carried across as a toggle
  lane_deskew_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(ovf_tgl), .q(ovf_s)
  );

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) ovf_d <= 1'b0;
    else           ovf_d <= ovf_s;
  end

  assign rd_ovf_evt = ovf_s ^ ovf_d;

endmodule

// File: rtl/lane_deskew_group_ctrl.sv
module lane_deskew_group_ctrl
  import lane_deskew_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int DW       = 8,
  parameter int MAX_SKEW = 18,
  parameter int CW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                group_mode,
  input  logic [LANES-1:0]    lane_empty,
  input  logic [LANES-1:0]    lane_sof,
  input  logic [LANES-1:0]    lane_ovf,
  input  logic [LANES*DW-1:0] lane_data,
  output logic [LANES-1:0]    lane_pop,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic [LANES-1:0]    out_sof,
  output logic                out_aligned,
  output logic                out_err,
  output logic                locked,
  output logic [CW-1:0]       wait_cnt
);

  function automatic logic sof_split(input logic [LANES-1:0] s);
    return (|s) && !(&s);
  endfunction

  grp_state_e       state_q, state_d;
  logic [LANES-1:0] present, holding, emit;
  logic             all_hold, any_hold, all_ready, ovf_hit;
  logic             skew_hit, split_hit, start_hit, grp_err;

  always_comb begin
    present   = ~lane_empty;
    holding   = present & lane_sof;
    all_hold  = &holding;
    any_hold  = |holding;
    all_ready = &present;
    ovf_hit   = |lane_ovf;
    skew_hit  = 1'b0;
    split_hit = 1'b0;
    start_hit = 1'b0;
    lane_pop  = '0;
    emit      = '0;
    state_d   = state_q;
    if (!group_mode) begin
      lane_pop = present;
      emit     = present;
      state_d  = GRP_HUNT;
    end else if (state_q == GRP_HUNT) begin
      if (all_hold) begin
        lane_pop  = '1;
        emit      = '1;
        start_hit = 1'b1;
        state_d   = GRP_LOCK;
      end else if (any_hold && skew_over(32'(wait_cnt), MAX_SKEW)) begin
        skew_hit = 1'b1;
        lane_pop = present;
      end else begin
        lane_pop = present & ~lane_sof;
      end
    end else if (all_ready) begin
      lane_pop = '1;
      if (sof_split(lane_sof)) begin
        split_hit = 1'b1;
      end else begin
        emit      = '1;
        start_hit = &lane_sof;
      end
    end
    grp_err = group_mode && (skew_hit || split_hit || ovf_hit);
    if (grp_err) begin
      emit      = '0;
      start_hit = 1'b0;
      state_d   = GRP_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GRP_HUNT;
      wait_cnt <= '0;
    end else begin
      state_q <= state_d;
      if (!group_mode || state_q == GRP_LOCK || !any_hold || all_hold || skew_hit)
        wait_cnt <= '0;
      else
        wait_cnt <= wait_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= '0;
      out_data    <= '0;
      out_sof     <= '0;
      out_aligned <= 1'b0;
      out_err     <= 1'b0;
    end else begin
      out_valid <= emit;
      out_data  <= lane_data;
      out_sof   <= lane_sof & emit;
      out_err   <= grp_err;
      if (!group_mode || grp_err) out_aligned <= 1'b0;
      else if (start_hit)         out_aligned <= 1'b1;
    end
  end

  assign locked = (state_q == GRP_LOCK);

endmodule

// File: rtl/lane_deskew_fifo.sv
module lane_deskew_fifo #(
  parameter int LANES       = 4,
  parameter int DW          = 8,
  parameter int DEPTH       = 32,
  parameter int MAX_SKEW    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rst_n,
  input  logic [LANES-1:0]    wr_clk,
  input  logic [LANES-1:0]    wr_valid,
  input  logic [LANES*DW-1:0] wr_data,
  input  logic [LANES-1:0]    wr_sof,
  input  logic                rd_clk,
  input  logic                group_mode,
  output logic [LANES-1:0]    rd_valid,
  output logic [LANES*DW-1:0] rd_data,
  output logic [LANES-1:0]    rd_sof,
  output logic                aligned,
  output logic                align_err
);

  localparam int CNT_W = lane_deskew_pkg::wait_width(MAX_SKEW);

  logic                rd_rst_n;
  logic [LANES-1:0]    fifo_empty, head_sof, ovf_evt, pop;
  logic [LANES*DW-1:0] head_data;
  logic                locked;
  logic [CNT_W-1:0]    skew_cnt;

  lane_deskew_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wr_rst_n;

    lane_deskew_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wr_rst (
      .clk(wr_clk[g]), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n)
    );

    lane_deskew_lane_fifo #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
      .wr_clk     (wr_clk[g]),
      .wr_rst_n   (wr_rst_n),
      .wr_valid   (wr_valid[g]),
      .wr_data    (wr_data[g*DW +: DW]),
      .wr_sof     (wr_sof[g]),
      .rd_clk     (rd_clk),
      .rd_rst_n   (rd_rst_n),
      .rd_pop     (pop[g]),
      .rd_empty   (fifo_empty[g]),
      .rd_head    (head_data[g*DW +: DW]),
      .rd_head_sof(head_sof[g]),
      .rd_ovf_evt (ovf_evt[g])
    );
  end

  lane_deskew_group_ctrl #(
    .LANES(LANES), .DW(DW), .MAX_SKEW(MAX_SKEW), .CW(CNT_W)
  ) u_ctrl (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .group_mode (group_mode),
    .lane_empty (fifo_empty),
    .lane_sof   (head_sof),
    .lane_ovf   (ovf_evt),
    .lane_data  (head_data),
    .lane_pop   (pop),
    .out_valid  (rd_valid),
    .out_data   (rd_data),
    .out_sof    (rd_sof),
    .out_aligned(aligned),
    .out_err    (align_err),
    .locked     (locked),
    .wait_cnt   (skew_cnt)
  );

endmodule

// File: rtl/lane_deskew_fifo_chk.sv
module lane_deskew_fifo_chk #(
  parameter int LANES    = 4,
  parameter int CNT_W    = 5,
  parameter int MAX_SKEW = 18
) (
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic             group_mode,
  input logic [LANES-1:0] rd_valid,
  input logic [LANES-1:0] rd_sof,
  input logic             aligned,
  input logic             align_err,
  input logic [LANES-1:0] fifo_empty,
  input logic [LANES-1:0] pop,
  input logic [CNT_W-1:0] skew_cnt
);

  // R3
  grp_valid_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (group_mode && |rd_valid) |-> &rd_valid);

  // R4
  grp_sof_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (group_mode && |rd_sof) |-> &rd_sof);

  // R1
  indep_status_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !group_mode |-> (!aligned && !align_err));

  // R5
  no_underrun_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (group_mode && (pop & fifo_empty) != '0) |-> 1'b0);

  // R6
  align_rise_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(aligned) |-> (&rd_sof && &rd_valid));

  // R7
  skew_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    32'(skew_cnt) <= MAX_SKEW + 1);

  // R7
  err_quiet_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    align_err |-> (rd_valid == '0));

  // R8
  err_unlock_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    align_err |-> !aligned);

endmodule

bind lane_deskew_fifo lane_deskew_fifo_chk #(
  .LANES(LANES), .CNT_W(CNT_W), .MAX_SKEW(MAX_SKEW)
) chk_i (
  .rd_clk    (rd_clk),
  .rd_rst_n  (rd_rst_n),
  .group_mode(group_mode),
  .rd_valid  (rd_valid),
  .rd_sof    (rd_sof),
  .aligned   (aligned),
  .align_err (align_err),
  .fifo_empty(fifo_empty),
  .pop       (pop),
  .skew_cnt  (skew_cnt)
);

// File: tb/lane_deskew_fifo_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_fifo_tb_top;

  localparam int L   = 4;
  localparam int DW  = 8;
  localparam int FRM = 64;
  localparam int OFS = 20;

  logic            rst_n;
  logic [L-1:0]    wr_clk;
  logic            rd_clk;
  logic [L-1:0]    wr_valid;
  logic [L*DW-1:0] wr_data;
  logic [L-1:0]    wr_sof;
  logic            group_mode;
  logic [L-1:0]    rd_valid;
  logic [L*DW-1:0] rd_data;
  logic [L-1:0]    rd_sof;
  logic            aligned;
  logic            align_err;

  int skew [L];
  int spur_lane;
  int spur_idx;
  bit run_en;
  bit run_mon;

  int n_chk;
  int n_fail;
  int words;
  int errs;
  bit need_sof;
  int last0;
  int d0;
  int lane_last [L];
  bit lane_have [L];
  int lane_words [L];

  lane_deskew_fifo dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sof(wr_sof), .rd_clk(rd_clk), .group_mode(group_mode),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_sof(rd_sof),
    .aligned(aligned), .align_err(align_err)
  );

  initial begin
    rd_clk = 1'b0;
    #0.5;
    forever #2.5 rd_clk = ~rd_clk;
  end

  for (genvar g = 0; g < L; g++) begin : g_src
    logic       wck;
    int         c;
    logic       v;
    logic [7:0] d;
    logic       s;

    initial begin
      wck = 1'b0;
      #(0.3 + 1.1 * g);
      forever #2.5 wck = ~wck;
    end

    always @(posedge wck) begin
      if (!run_en) begin
        c <= 0; v <= 1'b0; d <= 8'd0; s <= 1'b0;
      end else begin
        c <= c + 1;
        if (c >= skew[g]) begin
          v <= 1'b1;
          d <= 8'((c - skew[g] + OFS) % 256);
          s <= ((c - skew[g] + OFS) % FRM == 0) || (g == spur_lane && c - skew[g] == spur_idx);
        end else begin
          v <= 1'b0;
          s <= 1'b0;
        end
      end
    end

    assign wr_clk[g]          = wck;
    assign wr_valid[g]        = v;
    assign wr_data[g*DW +: DW] = d;
    assign wr_sof[g]          = s;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(negedge rd_clk) begin
    if (rst_n && run_mon) begin
      if (align_err) begin
        errs++;
        need_sof = 1'b1;
        chk(!aligned, "R8 aligned falls with error", int'(aligned), 0);
      end
      if (group_mode) begin
        if (|rd_valid) begin
          d0 = int'(rd_data[7:0]);
          words++;
          chk(&rd_valid, "R3 lanes valid together", int'(rd_valid), 15);
          for (int i = 1; i < L; i++)
            chk(int'(rd_data[i*DW +: DW]) == d0, "R4 lane position match", int'(rd_data[i*DW +: DW]), d0);
          chk(int'(rd_sof) == ((d0 % FRM == 0) ? 15 : 0), "R4 frame start on all lanes",
              int'(rd_sof), (d0 % FRM == 0) ? 15 : 0);
          chk(aligned, "R6 aligned while emitting", int'(aligned), 1);
          if (need_sof) begin
            chk(d0 % FRM == 0, "R2 first word is frame start", d0 % FRM, 0);
            need_sof = 1'b0;
          end else begin
            chk(d0 == (last0 + 1) % 256, "R5 contiguous stream", d0, (last0 + 1) % 256);
          end
          last0 = d0;
        end
      end else if (|rd_valid) begin
        chk(!aligned && !align_err, "R1 status low in independent mode",
            int'({aligned, align_err}), 0);
        for (int i = 0; i < L; i++) begin
          if (rd_valid[i]) begin
            int dv;
            dv = int'(rd_data[i*DW +: DW]);
            lane_words[i]++;
            if (!lane_have[i]) chk(dv == OFS, "R1 first byte kept", dv, OFS);
            else chk(dv == (lane_last[i] + 1) % 256, "R1 in-order bytes", dv, (lane_last[i] + 1) % 256);
            chk(rd_sof[i] == (dv % FRM == 0), "R1 marker carried", int'(rd_sof[i]), int'(dv % FRM == 0));
            lane_last[i] = dv;
            lane_have[i] = 1'b1;
          end
        end
      end
    end
  end

  task automatic scn(input bit gm, input int s0, input int s1, input int s2, input int s3,
                     input int sl, input int si, input int ncyc);
    rst_n = 1'b0;
    run_en = 1'b0;
    run_mon = 1'b0;
    group_mode = gm;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    spur_lane = sl;
    spur_idx = si;
    repeat (6) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(rd_valid == '0, "R9 valid low in reset", int'(rd_valid), 0);
    chk(!aligned, "R9 aligned low in reset", int'(aligned), 0);
    chk(!align_err, "R9 error low in reset", int'(align_err), 0);
    words = 0;
    errs = 0;
    need_sof = 1'b1;
    last0 = 0;
    for (int i = 0; i < L; i++) begin
      lane_have[i] = 1'b0;
      lane_words[i] = 0;
      lane_last[i] = 0;
    end
    rst_n = 1'b1;
    run_mon = 1'b1;
    repeat (8) @(posedge rd_clk);
    run_en = 1'b1;
    repeat (ncyc) @(posedge rd_clk);
  endtask

  initial begin
    repeat (60000) @(posedge rd_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    run_en = 1'b0;
    run_mon = 1'b0;
    rst_n = 1'b0;
    group_mode = 1'b0;
    spur_lane = -1;
    spur_idx = -1;
    for (int i = 0; i < L; i++) skew[i] = 0;

    // R1: independent lanes with unrelated skews
    scn(1'b0, 0, 7, 3, 11, -1, -1, 400);
    for (int i = 0; i < L; i++)
      chk(lane_words[i] >= 300, "R1 lane byte count", lane_words[i], 300);
    chk(errs == 0, "R1 no error pulse", errs, 0);

    // R4/R6: sweep of the group's spread of skew, up to 17 bytes
    for (int s = 0; s <= 17; s += 4) begin
      int sp;
      sp = (s > 17) ? 17 : s;
      scn(1'b1, sp / 3, 0, sp, sp / 2, -1, -1, 300);
      chk(words >= 150, "R4 words emitted", words, 150);
      chk(errs == 0, "R4 no error within skew bound", errs, 0);
      chk(aligned, "R6 aligned after lock", int'(aligned), 1);
    end
    scn(1'b1, 17, 0, 9, 4, -1, -1, 300);
    chk(words >= 150, "R4 words emitted at 17 byte skew", words, 150);
    chk(errs == 0, "R4 no error at 17 byte skew", errs, 0);
    chk(aligned, "R6 aligned at 17 byte skew", int'(aligned), 1);

    // R7: skew beyond the bound never locks
    scn(1'b1, 0, 0, 0, 24, -1, -1, 500);
    chk(words == 0, "R7 no data with excess skew", words, 0);
    chk(errs >= 1, "R7 error pulses seen", errs, 1);
    chk(!aligned, "R7 aligned stays low", int'(aligned), 0);

    // R8: false frame start on one lane while locked
    scn(1'b1, 2, 9, 0, 6, 1, 138, 700);
    chk(errs == 1, "R8 single error pulse", errs, 1);
    chk(aligned, "R8 relocked after error", int'(aligned), 1);
    chk(words >= 400, "R8 words emitted around error", words, 400);

    rst_n = 1'b0;
    run_en = 1'b0;
    repeat (4) @(posedge rd_clk);
    summary();
    $finish;
  end

endmodule